// File: doc/BRIEF.md
# Graphic LCD Host Bus Interface

This block sits between a microprocessor and the scan side of a 64-column graphic LCD segment driver. The processor talks to it over an 8-bit parallel bus with three chip selects, a register-select line, a read/write line and an enable strobe. The strobe is sampled on the internal clock. Through this bus the processor turns the display on or off, picks a page and a column, sets the line shown at the top of the screen, reads a status byte, and writes or reads display bytes.

The block owns a 512-byte display memory arranged as 8 pages of 64 bytes. The column counter steps by one after every data access. The page only changes when the processor sets it. Data reads go through an output register, so each read returns the byte fetched by the read before it, and the first read after an address change is a dummy. After every accepted operation a busy flag stays high for two clocks, and the block drops any access that arrives while it is high. The scan logic gets a second, read-only memory port together with the on/off state and the start line.

Top module: `glcd_host_if`

## Requirements
- R1: An access acts only when cs1_n=0, cs2_n=0 and cs3=1. With any other combination no instruction or data access changes state, and dout_oe stays 0.
- R2: {rs,rw} selects the access: 00 instruction write, 01 status read, 10 data write, 11 data read. An access takes effect when the enable strobe falls.
- R3: Instruction 0011111D sets disp_on to D. Memory contents are kept.
- R4: Instruction 01cccccc loads the 6-bit column counter. Instruction 10111ppp loads the 3-bit page register.
- R5: Instruction 11ssssss loads start_line with s.
- R6: A data write stores din at memory address page*64+column, then increments the column. The page is unchanged.
- R7: A data read latches the byte at page*64+column into an output register and increments the column. While the strobe is high, the bus shows the byte latched by the previous read, so the first read after setting an address is a dummy.
- R8: The column wraps from 63 to 0 without changing the page.
- R9: A status read drives {BUSY,0,OFF,RESET,0000} with no dummy cycle. OFF=1 means the display is off. dout_oe is 1 only while a selected read strobe is high.
- R10: Each accepted instruction or data access holds BUSY high for exactly 2 clocks. Instructions and data accesses whose strobe falls while BUSY is high are dropped.
- R11: While rst is high, disp_on and start_line are 0, the status RESET bit reads 1 (status 0x30), and every instruction is ignored.
- R12: scan_data shows the memory byte at scan_addr (page*64+column) one clock after scan_addr is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst | input | 1 | Synchronous active-high reset |
| cs1_n | input | 1 | Chip select, active low |
| cs2_n | input | 1 | Chip select, active low |
| cs3 | input | 1 | Chip select, active high |
| rs | input | 1 | 1 = display data, 0 = instruction/status |
| rw | input | 1 | 1 = read, 0 = write |
| en | input | 1 | Access strobe; writes act on its falling edge |
| din | input | 8 | Bus write data |
| dout | output | 8 | Bus read data |
| dout_oe | output | 1 | Drive enable for dout |
| scan_addr | input | 9 | Scan-side memory address {page, column} |
| scan_data | output | 8 | Scan-side memory byte |
| disp_on | output | 1 | Display on/off state |
| start_line | output | 6 | Display start line |

## Verification
The bench fills all 512 bytes and checks each one through both the scan port and the bus read path. A design that ignored the page or had an off-by-one in the output register would return shifted or wrong bytes. It hits the column wrap at 63: a design that carried into the page would corrupt the next page. It sends a second strobe that falls within the busy window and expects it to be dropped. A design that accepted it would move the column an extra step. It also drops each chip select in turn and issues an instruction while reset is held, to catch state changes where none should occur.

// File: rtl/glcd_pkg.sv
package glcd_pkg;
  localparam int BUS_W = 8;

  typedef enum logic [1:0] {
    ACC_CMD  = 2'b00,
    ACC_STAT = 2'b01,
    ACC_WR   = 2'b10,
    ACC_RD   = 2'b11
  } acc_e;
endpackage

// File: rtl/glcd_bus_sync.sv
module glcd_bus_sync
  import glcd_pkg::*;
(
  input  logic             clk,
  input  logic             cs1_n,
  input  logic             cs2_n,
  input  logic             cs3,
  input  logic             rs,
  input  logic             rw,
  input  logic             en,
  input  logic [BUS_W-1:0] din,
  output logic             rd_live_o,
  output logic             rs_live_o,
  output logic             cap_sel_o,
  output acc_e             cap_acc_o,
  output logic [BUS_W-1:0] cap_d_o,
  output logic             fall_o
);
  logic             s1_sel, s1_e, s1_rs, s1_rw;
  logic [BUS_W-1:0] s1_d;
  logic             s2_sel, s2_e, s2_rs, s2_rw;
  logic [BUS_W-1:0] s2_d;

  always_ff @(posedge clk) begin
    s1_sel <= ~cs1_n & ~cs2_n & cs3;
    s1_e   <= en;
    s1_rs  <= rs;
    s1_rw  <= rw;
    s1_d   <= din;
    s2_sel <= s1_sel;
    s2_e   <= s1_e;
    s2_rs  <= s1_rs;
    s2_rw  <= s1_rw;
    s2_d   <= s1_d;
  end

  assign rd_live_o = s1_e & s1_sel & s1_rw;
  assign rs_live_o = s1_rs;
  assign cap_sel_o = s2_sel;
  assign cap_acc_o = acc_e'({s2_rs, s2_rw});
  assign cap_d_o   = s2_d;
  assign fall_o    = s2_e & ~s1_e;
endmodule

// File: rtl/glcd_dpram.sv
module glcd_dpram #(
  parameter int AW = 9,
  parameter int DW = 8,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          a_we,
  input  logic [AW-1:0] a_addr,
  input  logic [DW-1:0] a_wdata,
  output logic [DW-1:0] a_rdata,
  input  logic [AW-1:0] b_addr,
  output logic [DW-1:0] b_rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (a_we) mem[a_addr] <= a_wdata;
    a_rdata <= mem[a_addr];
  end

  always_ff @(posedge clk) begin
    b_rdata <= mem[b_addr];
  end
endmodule

// File: rtl/glcd_ctrl.sv
module glcd_ctrl
  import glcd_pkg::*;
#(
  parameter int COLS     = 64,
  parameter int PAGES    = 8,
  parameter int BUSY_CYC = 2,
  localparam int CW  = $clog2(COLS),
  localparam int PW  = $clog2(PAGES),
  localparam int AW  = CW + PW,
  localparam int BCW = $clog2(BUSY_CYC + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_live_i,
  input  logic             rs_live_i,
  input  logic             cap_sel_i,
  input  acc_e             cap_acc_i,
  input  logic [BUS_W-1:0] cap_d_i,
  input  logic             fall_i,
  output logic             ram_we,
  output logic [AW-1:0]    ram_addr,
  output logic [BUS_W-1:0] ram_wdata,
  input  logic [BUS_W-1:0] ram_rdata,
  output logic [BUS_W-1:0] dout,
  output logic             dout_oe,
  output logic             disp_on,
  output logic [CW-1:0]    start_line
);
  logic [CW-1:0]    col;
  logic [PW-1:0]    page;
  logic [BCW-1:0]   busy_cnt;
  logic             busy, rst_flag, rd_pend;
  logic [BUS_W-1:0] out_reg, status;
  logic             go, wr_go, rd_go, cmd_go;

  assign busy   = (busy_cnt != '0);
  assign go     = fall_i & cap_sel_i & ~busy & ~rst_flag;
  assign wr_go  = go & (cap_acc_i == ACC_WR);
  assign rd_go  = go & (cap_acc_i == ACC_RD);
  assign cmd_go = go & (cap_acc_i == ACC_CMD);

  assign ram_we    = wr_go;
  assign ram_addr  = {page, col};
  assign ram_wdata = cap_d_i;
  assign status    = {busy, 1'b0, ~disp_on, rst_flag, 4'b0000};

  always_ff @(posedge clk) begin
    if (rst) begin
      disp_on    <= 1'b0;
      start_line <= '0;
      col        <= '0;
      page       <= '0;
      busy_cnt   <= '0;
      rd_pend    <= 1'b0;
      out_reg    <= '0;
      rst_flag   <= 1'b1;
    end else begin
      rst_flag <= 1'b0;
      rd_pend  <= rd_go;
      if (rd_pend) out_reg <= ram_rdata;
      if (busy) busy_cnt <= busy_cnt - 1'b1;
      if (go && cap_acc_i != ACC_STAT) busy_cnt <= BCW'(BUSY_CYC);
      if (wr_go || rd_go) col <= col + 1'b1;
      if (cmd_go) begin
        casez (cap_d_i)
          8'b0011111?: disp_on    <= cap_d_i[0];
          8'b01??????: col        <= cap_d_i[CW-1:0];
          8'b10111???: page       <= cap_d_i[PW-1:0];
          8'b11??????: start_line <= cap_d_i[CW-1:0];
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    dout_oe <= rd_live_i;
    dout    <= rs_live_i ? out_reg : status;
  end

  AST_RST_CLEAR: assert property (@(posedge clk)
    rst |=> (!disp_on && start_line == '0 && col == '0 && page == '0)); // R11
  AST_NOSEL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (fall_i && !cap_sel_i) |=> ($stable(col) && $stable(page) &&
                                $stable(start_line) && $stable(disp_on))); // R1
  AST_BUSY_DROP: assert property (@(posedge clk) disable iff (rst)
    (fall_i && busy) |=> ($stable(col) && $stable(page) &&
                          $stable(start_line) && $stable(disp_on))); // R10
  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |=> busy); // R10
  AST_COL_WRAP: assert property (@(posedge clk) disable iff (rst)
    ((wr_go || rd_go) && col == CW'(COLS - 1)) |=> (col == '0 && $stable(page))); // R8
  AST_DATA_STEP: assert property (@(posedge clk) disable iff (rst)
    (wr_go || rd_go) |=> (col == $past(col) + 1'b1)); // R6
endmodule

// File: rtl/glcd_host_if.sv
module glcd_host_if
  import glcd_pkg::*;
#(
  parameter int COLS     = 64,
  parameter int PAGES    = 8,
  parameter int BUSY_CYC = 2,
  localparam int CW = $clog2(COLS),
  localparam int PW = $clog2(PAGES),
  localparam int AW = CW + PW
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cs1_n,
  input  logic             cs2_n,
  input  logic             cs3,
  input  logic             rs,
  input  logic             rw,
  input  logic             en,
  input  logic [BUS_W-1:0] din,
  output logic [BUS_W-1:0] dout,
  output logic             dout_oe,
  input  logic [AW-1:0]    scan_addr,
  output logic [BUS_W-1:0] scan_data,
  output logic             disp_on,
  output logic [CW-1:0]    start_line
);
  logic             rd_live, rs_live, cap_sel, fall;
  acc_e             cap_acc;
  logic [BUS_W-1:0] cap_d;
  logic             ram_we;
  logic [AW-1:0]    ram_addr;
  logic [BUS_W-1:0] ram_wdata, ram_rdata;

  glcd_bus_sync i_sync (
    .clk(clk), .cs1_n(cs1_n), .cs2_n(cs2_n), .cs3(cs3), .rs(rs), .rw(rw),
    .en(en), .din(din), .rd_live_o(rd_live), .rs_live_o(rs_live),
    .cap_sel_o(cap_sel), .cap_acc_o(cap_acc), .cap_d_o(cap_d), .fall_o(fall)
  );

  glcd_ctrl #(.COLS(COLS), .PAGES(PAGES), .BUSY_CYC(BUSY_CYC)) i_ctrl (
    .clk(clk), .rst(rst), .rd_live_i(rd_live), .rs_live_i(rs_live),
    .cap_sel_i(cap_sel), .cap_acc_i(cap_acc), .cap_d_i(cap_d), .fall_i(fall),
    .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
    .ram_rdata(ram_rdata), .dout(dout), .dout_oe(dout_oe),
    .disp_on(disp_on), .start_line(start_line)
  );

  glcd_dpram #(.AW(AW), .DW(BUS_W)) i_ram (
    .clk(clk), .a_we(ram_we), .a_addr(ram_addr), .a_wdata(ram_wdata),
    .a_rdata(ram_rdata), .b_addr(scan_addr), .b_rdata(scan_data)
  );
endmodule

// File: tb/test_glcd_host_if.sv
module test_glcd_host_if;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cs1_n = 1'b0, cs2_n = 1'b0, cs3 = 1'b1;
  logic       rs = 1'b0, rw = 1'b0, en = 1'b0;
  logic [7:0] din = '0;
  logic [7:0] dout, scan_data;
  logic       dout_oe, disp_on;
  logic [8:0] scan_addr = '0;
  logic [5:0] start_line;

  int n_chk = 0, n_bad = 0;
  logic [7:0] last_dout;
  logic       last_oe;
  logic [7:0] exp_mem [512];

  always #5 clk = ~clk;

  glcd_host_if i_glcd_host_if (
    .clk(clk), .rst(rst), .cs1_n(cs1_n), .cs2_n(cs2_n), .cs3(cs3),
    .rs(rs), .rw(rw), .en(en), .din(din), .dout(dout), .dout_oe(dout_oe),
    .scan_addr(scan_addr), .scan_data(scan_data), .disp_on(disp_on),
    .start_line(start_line)
  );

  function automatic logic [7:0] pat(int p, int c);
    return 8'(((p * 29) + (c * 7) + 3) ^ (c << 3));
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic bus(logic r_s, logic r_w, logic [7:0] d);
    rs = r_s; rw = r_w; din = d; en = 1'b1;
    repeat (4) @(negedge clk);
    last_dout = dout; last_oe = dout_oe;
    en = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic cmd(logic [7:0] d); bus(1'b0, 1'b0, d); endtask
  task automatic wr(logic [7:0] d); bus(1'b1, 1'b0, d); endtask

  task automatic scan_chk(string tag, int p, int c);
    scan_addr = 9'(p * 64 + c);
    repeat (2) @(negedge clk);
    chk(tag, 32'(scan_data), 32'(exp_mem[p * 64 + c]));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] prev;
    for (int i = 0; i < 512; i++) exp_mem[i] = 8'h00;
    repeat (5) @(negedge clk);
    // R11: status and outputs while reset is held
    bus(1'b0, 1'b1, 8'h00);
    chk("R11 status in reset", 32'(last_dout), 32'h30);
    chk("R9 oe on status read", 32'(last_oe), 32'h1);
    cmd(8'h3F);
    chk("R11 cmd ignored in reset", 32'(disp_on), 32'h0);
    chk("R11 start line in reset", 32'(start_line), 32'h0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    bus(1'b0, 1'b1, 8'h00);
    chk("R9 status after reset", 32'(last_dout), 32'h20);

    // R3 on/off
    cmd(8'h3F);
    chk("R3 on", 32'(disp_on), 32'h1);
    bus(1'b0, 1'b1, 8'h00);
    chk("R9 R3 status on", 32'(last_dout), 32'h00);
    cmd(8'h3E);
    chk("R3 off", 32'(disp_on), 32'h0);
    cmd(8'h3F);
    // R5 start line
    cmd(8'hC0 | 8'd21);
    chk("R5 start 21", 32'(start_line), 32'd21);
    cmd(8'hFF);
    chk("R5 start 63", 32'(start_line), 32'd63);

    // R4 R6 fill every byte
    for (int p = 0; p < 8; p++) begin
      cmd(8'hB8 | 8'(p));
      cmd(8'h40);
      for (int c = 0; c < 64; c++) begin
        wr(pat(p, c));
        exp_mem[p * 64 + c] = pat(p, c);
      end
    end
    // R12 R6 scan every byte
    for (int p = 0; p < 8; p++)
      for (int c = 0; c < 64; c++) scan_chk("R12 R6 scan", p, c);

    // R7 R8 R2 read back with dummy read
    prev = 8'h00;
    for (int p = 0; p < 8; p++) begin
      cmd(8'hB8 | 8'(p));
      cmd(8'h40);
      bus(1'b1, 1'b1, 8'h00);
      chk("R7 dummy read", 32'(last_dout), 32'(prev));
      for (int c = 0; c < 64; c++) begin
        bus(1'b1, 1'b1, 8'h00);
        chk("R7 R2 data read", 32'(last_dout), 32'(pat(p, c)));
      end
      prev = pat(p, 0);
    end

    // R8 wrap on writes
    cmd(8'hBA); cmd(8'h40 | 8'd63);
    wr(8'hA5); wr(8'h5A);
    exp_mem[2 * 64 + 63] = 8'hA5;
    exp_mem[2 * 64 + 0]  = 8'h5A;
    scan_chk("R8 col 63", 2, 63);
    scan_chk("R8 wrap to col 0", 2, 0);
    scan_chk("R8 next page untouched", 3, 0);

    // R1 chip select gating
    cmd(8'hBC); cmd(8'h40 | 8'd9);
    cs1_n = 1'b1; cmd(8'h40 | 8'd5); wr(8'h11); cs1_n = 1'b0;
    cs2_n = 1'b1; wr(8'h22); cmd(8'h3E); cs2_n = 1'b0;
    cs3 = 1'b0; wr(8'h33); cmd(8'hC5);
    bus(1'b0, 1'b1, 8'h00);
    chk("R1 oe off when deselected", 32'(last_oe), 32'h0);
    cs3 = 1'b1;
    chk("R1 disp unchanged", 32'(disp_on), 32'h1);
    chk("R1 start unchanged", 32'(start_line), 32'd63);
    wr(8'h77);
    exp_mem[4 * 64 + 9] = 8'h77;
    scan_chk("R1 write lands at col 9", 4, 9);
    scan_chk("R1 col 5 untouched", 4, 5);
    scan_chk("R1 col 10 untouched", 4, 10);

    // R10 second strobe inside busy window is dropped
    cmd(8'hBD); cmd(8'h40 | 8'd10);
    rs = 1'b1; rw = 1'b0; din = 8'hC3; en = 1'b1;
    @(negedge clk); en = 1'b0;
    @(negedge clk); din = 8'h3C; en = 1'b1;
    @(negedge clk); en = 1'b0;
    repeat (8) @(negedge clk);
    exp_mem[5 * 64 + 10] = 8'hC3;
    scan_chk("R10 first write", 5, 10);
    scan_chk("R10 dropped write", 5, 11);
    wr(8'h96);
    exp_mem[5 * 64 + 11] = 8'h96;
    scan_chk("R10 column not advanced by drop", 5, 11);

    // R10 busy flag visible right after a write
    rs = 1'b1; rw = 1'b0; din = 8'h44; en = 1'b1;
    repeat (4) @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    rs = 1'b0; rw = 1'b1; en = 1'b1;
    repeat (2) @(negedge clk);
    chk("R10 busy set", 32'(dout), 32'h80);
    repeat (4) @(negedge clk);
    chk("R10 busy cleared", 32'(dout), 32'h00);
    en = 1'b0;
    repeat (6) @(negedge clk);

    // R11 reset mid-run
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    chk("R11 off after reset", 32'(disp_on), 32'h0);
    chk("R11 start cleared", 32'(start_line), 32'h0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    scan_chk("R11 memory kept", 5, 11);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule